// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This unit sits beside the datapath of a flash memory controller. It takes the condition levels and event strobes that the datapath produces and turns them into two register views and one interrupt line. A live status view shows the present ready conditions together with the outcome of the most recent ECC decode, including how many symbols that decode corrected. A pending view latches each event as it happens. It is gated by a software-written enable mask and drives a single active-high, level-sensitive interrupt.

Software clears the pending view by reading it: one read returns every latched event and empties the register. An event that lands in the same cycle as that read survives it. The live view is read-only. Software treats the attached memory as fully idle only when both the controller-ready and device-ready bits of the live view are set. The register port is a plain single-cycle read/write strobe with combinational read data. No data stream crosses this block, so it has no valid/ready interface and applies no back-pressure.

Top module: `fic_irq_status`

## Requirements
- R1: After reset the mask (address 0), the pending register (address 1) and the live view (address 2, with all inputs low) read as zero, and `irq_o` is low.
- R2: Pending bit positions: bit 5 is set by a rising edge of `dev_rdy_i`, bit 4 by a rising edge of `ctl_rdy_i`, bit 3 by `dec_done_i` with `dec_fail_i`, bit 2 by `dec_done_i` with `dec_err_i`, bit 1 by a rising edge of `ecc_rdy_i`, and bit 0 by `wp_fault_i`. Bits 7:6 read as zero.
- R3: A read of address 1 returns the latched bits and clears them all at that clock edge.
- R4: An event arriving in the same cycle as a clearing read of address 1 is still set after the read.
- R5: `irq_o` is high exactly while the bitwise AND of the pending and mask registers is non-zero.
- R6: Address 0 is read/write. Bits 5:0 hold the mask, bits 7:6 read as zero, and the mask never stops an event from latching.
- R7: Live view bits 0, 1 and 2 follow `dev_rdy_i`, `ctl_rdy_i` and `ecc_rdy_i` in the same cycle.
- R8: On each `dec_done_i`, live bit 6 takes `dec_fail_i` and bit 3 takes `dec_err_i`. Bits 5:4 take `dec_nsym_i - 1` when `dec_err_i` is set, and zero otherwise. These bits hold their value between completions. Bit 7 reads as zero.
- R9: Writes to addresses 1, 2 and 3 change nothing, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_rdy_i | input | 1 | Memory device ready level |
| ctl_rdy_i | input | 1 | Controller ready level |
| ecc_rdy_i | input | 1 | ECC engine ready level |
| dec_done_i | input | 1 | Decode completion strobe |
| dec_fail_i | input | 1 | Decode uncorrectable, valid with strobe |
| dec_err_i | input | 1 | Decode found and corrected errors, valid with strobe |
| dec_nsym_i | input | 3 | Corrected symbol count (1..4), valid with strobe and error |
| wp_fault_i | input | 1 | Write-protect fault strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
A pending bit stuck high, or lost at a clearing read, shows on `irq_o` one edge after the read once its mask bit is enabled, and it shows in the next read of address 1. A wrong mask bit shows up within the sweep of every pending pattern against every mask value, because `irq_o` then disagrees for at least one combination on the edge after the mask write. A wrong stored decode field shows up on the first read of the live view after the completion that loaded it. The bench also reads the view after a cycle with no completion, so a field that fails to hold is seen there.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int NEV     = 6;
  localparam int CNT_W   = 2;
  localparam int NSYM_W  = CNT_W + 1;
  localparam int NLVL    = 3;

  typedef enum logic [AW-1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_LIVE = 2'd2,
    SEL_NONE = 2'd3
  } fic_sel_e;

  localparam int EV_WP   = 0;
  localparam int EV_ECC  = 1;
  localparam int EV_DERR = 2;
  localparam int EV_DFL  = 3;
  localparam int EV_CTL  = 4;
  localparam int EV_DEV  = 5;

  localparam int LV_DEV  = 0;
  localparam int LV_CTL  = 1;
  localparam int LV_ECC  = 2;
endpackage

// File: rtl/fic_edge_detect.sv
module fic_edge_detect #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_rise
      assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/fic_pend_latch.sv
module fic_pend_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] pend_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_i) | set_i[g];
      end
      assign pend_o[g] = q;
    end
  endgenerate
endmodule

// File: rtl/fic_live_status.sv
module fic_live_status
  import fic_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] lvl_i,
  input  logic            done_i,
  input  logic            fail_i,
  input  logic            err_i,
  input  logic [CW:0]     nsym_i,
  output logic [DW-1:0]   live_o
);
  localparam int LIVE_W = NLVL + 2 + CW;

  logic          fail_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_full;

  assign cnt_full = nsym_i - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (done_i) begin
      fail_q <= fail_i;
      err_q  <= err_i;
      cnt_q  <= err_i ? cnt_full[CW-1:0] : '0;
    end
  end

  logic [LIVE_W-1:0] packed_v;
  assign packed_v = {fail_q, cnt_q, err_q, lvl_i};

  generate
    if (LIVE_W < DW) begin : g_pad
      assign live_o = {{(DW-LIVE_W){1'b0}}, packed_v};
    end else begin : g_nopad
      assign live_o = packed_v[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/fic_irq_status.sv
module fic_irq_status
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rdy_i,
  input  logic              ctl_rdy_i,
  input  logic              ecc_rdy_i,
  input  logic              dec_done_i,
  input  logic              dec_fail_i,
  input  logic              dec_err_i,
  input  logic [NSYM_W-1:0] dec_nsym_i,
  input  logic              wp_fault_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o
);
  logic [NLVL-1:0] lvl, rise;
  logic [NEV-1:0]  ev_set, pend, mask_q;
  logic [DW-1:0]   live;
  logic            clr_pend;
  fic_sel_e        sel;

  assign sel = fic_sel_e'(bus_addr_i);
  assign lvl = {ecc_rdy_i, ctl_rdy_i, dev_rdy_i};

  fic_edge_detect #(.W(NLVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_WP]   = wp_fault_i;
    ev_set[EV_ECC]  = rise[LV_ECC];
    ev_set[EV_DERR] = dec_done_i & dec_err_i;
    ev_set[EV_DFL]  = dec_done_i & dec_fail_i;
    ev_set[EV_CTL]  = rise[LV_CTL];
    ev_set[EV_DEV]  = rise[LV_DEV];
  end

  assign clr_pend = bus_rd_i && (sel == SEL_PEND);

  fic_pend_latch #(.N(NEV)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(clr_pend), .pend_o(pend)
  );

  fic_live_status u_live (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .done_i(dec_done_i),
    .fail_i(dec_fail_i), .err_i(dec_err_i), .nsym_i(dec_nsym_i), .live_o(live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                              mask_q <= '0;
    else if (bus_wr_i && (sel == SEL_MASK))  mask_q <= bus_wdata_i[NEV-1:0];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (sel)
        SEL_MASK: bus_rdata_o = {{(DW-NEV){1'b0}}, mask_q};
        SEL_PEND: bus_rdata_o = {{(DW-NEV){1'b0}}, pend};
        SEL_LIVE: bus_rdata_o = live;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(pend & mask_q);
endmodule

// File: rtl/fic_irq_status_chk.sv
module fic_irq_status_chk
  import fic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wp_fault_i,
  input logic              dec_done_i,
  input logic              dec_fail_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [NEV-1:0]    pend,
  input logic [NEV-1:0]    mask_q,
  input logic [DW-1:0]     live,
  input logic              irq_o
);
  // R2: write-protect fault latches bit 0
  a_r2_wp_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fault_i |=> pend[EV_WP]);
  // R3: clearing read with no new event empties pending and drops irq
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 2'd1 && !wp_fault_i && !dec_done_i) |=> (pend[EV_WP] == 1'b0) && (pend[EV_DFL] == 1'b0));
  // R4: event coinciding with clearing read survives
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 2'd1 && dec_done_i && dec_fail_i) |=> pend[EV_DFL]);
  // R6: mask write takes the low bits of write data
  a_r6_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd0) |=> mask_q == $past(bus_wdata_i[NEV-1:0]));
  // R5: with mask zero the interrupt stays low
  a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  // R8: decode fields hold between completions
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_done_i |=> $stable(live[6:3]));
endmodule

bind fic_irq_status fic_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_fault_i(wp_fault_i), .dec_done_i(dec_done_i),
  .dec_fail_i(dec_fail_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .pend(pend),
  .mask_q(mask_q), .live(live), .irq_o(irq_o)
);

// File: tb/test_fic_irq_status.sv
module test_fic_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_rdy = 0, ctl_rdy = 0, ecc_rdy = 0;
  logic dec_done = 0, dec_fail = 0, dec_err = 0, wp_fault = 0;
  logic [2:0] dec_nsym = 3'd1;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fic_irq_status i_fic_irq_status (
    .clk(clk), .rst_n(rst_n), .dev_rdy_i(dev_rdy), .ctl_rdy_i(ctl_rdy),
    .ecc_rdy_i(ecc_rdy), .dec_done_i(dec_done), .dec_fail_i(dec_fail),
    .dec_err_i(dec_err), .dec_nsym_i(dec_nsym), .wp_fault_i(wp_fault),
    .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  // one cycle of events by pending bit pattern, levels drop afterwards
  task automatic fire(input logic [5:0] p);
    @(negedge clk);
    dev_rdy = p[5]; ctl_rdy = p[4]; ecc_rdy = p[1]; wp_fault = p[0];
    dec_done = p[3] | p[2]; dec_fail = p[3]; dec_err = p[2]; dec_nsym = 3'd1;
    @(posedge clk); #1;
    dev_rdy = 0; ctl_rdy = 0; ecc_rdy = 0; wp_fault = 0;
    dec_done = 0; dec_fail = 0; dec_err = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rd(2'd0, d); chk("R1 mask", d, 8'h00);
    rd(2'd1, d); chk("R1 pend", d, 8'h00);
    rd(2'd2, d); chk("R1 live", d, 8'h00);
    // R6 mask width
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R6 mask readback", d, 8'h3F);
    // R2/R3/R5 sweep all pending patterns against all masks
    for (int p = 0; p < 64; p++) begin
      wr(2'd0, 8'h00);
      fire(p[5:0]);
      for (int m = 0; m < 64; m++) begin
        wr(2'd0, m[7:0]);
        chk("R5 irq", {7'd0, irq}, {7'd0, |(p[5:0] & m[5:0])});
      end
      rd(2'd1, d); chk("R2 R6 pend pattern", d, p[7:0]);
      rd(2'd1, d); chk("R3 cleared", d, 8'h00);
      chk("R3 irq after clear", {7'd0, irq}, 8'd0);
    end
    // R4 event during clearing read
    fire(6'h08);
    @(negedge clk);
    bus_rd = 1; bus_addr = 2'd1; wp_fault = 1;
    #1 chk("R4 read value", bus_rdata, 8'h08);
    @(posedge clk); #1; bus_rd = 0; wp_fault = 0;
    rd(2'd1, d); chk("R4 event kept", d, 8'h01);
    // R7 live levels
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dev_rdy = v[0]; ctl_rdy = v[1]; ecc_rdy = v[2];
      bus_rd = 1; bus_addr = 2'd2;
      #1 chk("R7 live ready bits", bus_rdata & 8'h07, v[7:0]);
      @(posedge clk); #1; bus_rd = 0;
    end
    @(negedge clk); dev_rdy = 0; ctl_rdy = 0; ecc_rdy = 0;
    // R8 decode result sweep
    for (int f = 0; f < 2; f++)
      for (int e = 0; e < 2; e++)
        for (int n = 1; n <= 4; n++) begin
          logic [7:0] exp;
          @(negedge clk);
          dec_done = 1; dec_fail = f[0]; dec_err = e[0]; dec_nsym = n[2:0];
          @(posedge clk); #1;
          dec_done = 0; dec_fail = ~f[0]; dec_err = ~e[0]; dec_nsym = 3'd3;
          exp = {1'b0, f[0], (e[0] ? 2'(n - 1) : 2'd0), e[0], 3'b000};
          rd(2'd2, d); chk("R8 decode fields", d, exp);
          rd(2'd2, d); chk("R8 decode hold", d, exp);
        end
    rd(2'd1, d);
    // R9 writes elsewhere ignored
    wr(2'd0, 8'h00);
    fire(6'h01);
    rd(2'd2, d);
    begin
      logic [7:0] live0;
      live0 = d;
      wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
      rd(2'd0, d); chk("R9 mask untouched", d, 8'h00);
      rd(2'd2, d); chk("R9 live untouched", d, live0);
      rd(2'd3, d); chk("R9 addr3 zero", d, 8'h00);
      rd(2'd1, d); chk("R9 pend untouched", d, 8'h01);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule